// File: doc/BRIEF.md
# Console Keyboard and Display Port

This peripheral sits on a simple processor memory bus and gives software one
keyboard receiver and one display transmitter through four word-sized slots in
a 16-byte window. Each slot is decoded from a word address. A key byte that
arrives on a byte-valid input is held in a one-byte receive buffer. A byte that
software writes to the transmit slot goes out on a valid/acknowledge handshake
toward the display.

Each direction has a ready flag and an interrupt-enable flag. Only the hardware
moves the ready flags. Bus writes to the control slots are discarded, so the two
enable flags are loaded through a separate configuration input. The receive side
also keeps a sticky overrun flag. A single level-sensitive interrupt request is
raised while either direction is ready and enabled.

Read data is combinational from the current bus inputs. Read side effects take
effect at the clock edge that ends the access.

Top module: `console_mmio`

## Requirements
- R1: With the window base at 0xFFFF0000, slot index = address bits 3:2: index 0 is the receive control word, index 1 the receive data word, index 2 the transmit control word, and index 3 the transmit data word. Address bits 1:0 are ignored. A read outside the window, a cycle without bus_sel, or a write cycle returns 0.
- R2: After reset, receive ready, both enables and overrun are 0, transmit ready is 1, both data bytes are 0, and irq and disp_valid are 0.
- R3: A cycle with key_valid high stores key_byte and makes receive ready 1 from the next cycle on.
- R4: A read of the receive data slot returns the byte in bits 7:0, with bits 31:8 zero. Receive ready is 0 from the next cycle unless a key byte arrives in the same cycle; in that case ready stays 1, the new byte is stored, and no overrun is flagged.
- R5: A key byte that arrives while receive ready is 1 and no receive-data read occurs in that cycle overwrites the data and sets overrun (bit 2 of the receive control word). A read of the receive control word clears overrun unless a new overrun occurs in the same cycle.
- R6: A write to the transmit data slot while transmit ready is 1 stores wdata bits 7:0 and drives them on disp_byte. Transmit ready drops to 0 and disp_valid rises from the next cycle. Both hold until a cycle with disp_ack, after which ready is 1 and disp_valid 0.
- R7: A write to the transmit data slot while transmit ready is 0 is discarded, and disp_byte keeps its value.
- R8: Bus writes to either control slot or to the receive data slot change no state.
- R9: A cycle with cfg_load copies cfg_rx_ie and cfg_tx_ie into bit 1 of the receive and transmit control words, respectively. Bit 0 of each control word is its ready flag.
- R10: irq is 1 exactly when (receive ready and receive enable) or (transmit ready and transmit enable).
- R11: disp_ack while transmit ready is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access |
| key_valid | input | 1 | Key byte present this cycle |
| key_byte | input | 8 | Incoming key byte |
| disp_valid | output | 1 | Byte waiting for the display |
| disp_byte | output | 8 | Byte for the display |
| disp_ack | input | 1 | Display has taken the byte |
| cfg_load | input | 1 | Load the enable flags |
| cfg_rx_ie | input | 1 | Receive interrupt enable value |
| cfg_tx_ie | input | 1 | Transmit interrupt enable value |
| irq | output | 1 | Interrupt request |

## Verification
A key byte can arrive in the same cycle as a receive-data read, and a new overrun can be raised in the same cycle as a receive-control read. Directed steps place key_valid and the read strobe in one cycle. The bench then checks three things: the read returned the older byte, the following control read shows ready still set, and the overrun flag is as R4 and R5 require. A behavioural model updated on every edge judges each cycle. A long stretch of random bus, key, acknowledge and configuration traffic then exercises these collisions many more times.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;

  typedef enum logic [1:0] {
    SLOT_RX_CTRL = 2'd0,
    SLOT_RX_DATA = 2'd1,
    SLOT_TX_CTRL = 2'd2,
    SLOT_TX_DATA = 2'd3
  } slot_e;

  localparam int unsigned SLOT_LSB     = 2;
  localparam int unsigned WINDOW_BITS  = SLOT_LSB + 2;
  localparam int unsigned CTRL_RDY_BIT = 0;
  localparam int unsigned CTRL_IE_BIT  = 1;
  localparam int unsigned CTRL_OVR_BIT = 2;

  typedef struct packed {
    logic  hit;
    logic  rd;
    logic  wr;
    slot_e slot;
  } access_t;

endpackage

// File: rtl/console_rst_sync.sv
module console_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= 1'b0;
        end else begin
          if (s == 0) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/console_decode.sv
module console_decode
  import console_mmio_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]     BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output access_t           acc
);

  logic addr_unused;
  assign addr_unused = ^bus_addr[SLOT_LSB-1:0];

  always_comb begin
    acc.hit  = bus_sel &&
               (bus_addr[ADDR_W-1:WINDOW_BITS] == BASE_ADDR[ADDR_W-1:WINDOW_BITS]);
    acc.rd   = acc.hit && !bus_we;
    acc.wr   = acc.hit &&  bus_we;
    acc.slot = slot_e'(bus_addr[WINDOW_BITS-1:SLOT_LSB]);
  end

endmodule

// File: rtl/console_rx_port.sv
module console_rx_port #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic              rd_data,
  input  logic              rd_ctrl,
  input  logic              cfg_load,
  input  logic              cfg_ie,
  output logic              rdy,
  output logic              ie,
  output logic              ovr,
  output logic [BYTE_W-1:0] data
);

  logic rdy_d, ovr_d, ovr_set, data_en;

  always_comb begin
    data_en = key_valid;
    ovr_set = key_valid && rdy && !rd_data;
    rdy_d   = rdy;
    if (key_valid)    rdy_d = 1'b1;
    else if (rd_data) rdy_d = 1'b0;
    ovr_d = ovr;
    if (ovr_set)      ovr_d = 1'b1;
    else if (rd_ctrl) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      ovr  <= 1'b0;
      ie   <= 1'b0;
      data <= '0;
    end else begin
      rdy <= rdy_d;
      ovr <= ovr_d;
      if (cfg_load) ie   <= cfg_ie;
      if (data_en)  data <= key_byte;
    end
  end

  p_key_sets_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (rdy && data == $past(key_byte)));

  p_read_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !key_valid) |=> !rdy);

  p_overrun_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && rdy && !rd_data) |=> ovr);

endmodule

// File: rtl/console_tx_port.sv
module console_tx_port #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              ack,
  input  logic              cfg_load,
  input  logic              cfg_ie,
  output logic              rdy,
  output logic              ie,
  output logic [BYTE_W-1:0] data
);

  logic accept, done, rdy_d;

  always_comb begin
    accept = wr_data && rdy;
    done   = ack && !rdy;
    rdy_d  = rdy;
    if (accept)    rdy_d = 1'b0;
    else if (done) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= 1'b1;
      ie   <= 1'b0;
      data <= '0;
    end else begin
      rdy <= rdy_d;
      if (cfg_load) ie   <= cfg_ie;
      if (accept)   data <= wbyte;
    end
  end

  p_busy_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && rdy) |=> (!rdy && data == $past(wbyte)));

  p_busy_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !rdy) |=> $stable(data));

  p_idle_ack_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rdy && !wr_data) |=> rdy);

endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_mmio_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       BYTE_W    = 8,
  parameter int unsigned       SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_valid,
  input  logic [BYTE_W-1:0] key_byte,
  output logic              disp_valid,
  output logic [BYTE_W-1:0] disp_byte,
  input  logic              disp_ack,
  input  logic              cfg_load,
  input  logic              cfg_rx_ie,
  input  logic              cfg_tx_ie,
  output logic              irq
);

  logic              rst_sync_n;
  access_t           acc;
  logic              rx_rdy, rx_ie, rx_ovr, tx_rdy, tx_ie;
  logic [BYTE_W-1:0] rx_data, tx_data;
  logic              rd_rx_data, rd_rx_ctrl, wr_tx_data, wr_ctrl;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:BYTE_W];

  console_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  console_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .acc      (acc)
  );

  always_comb begin
    rd_rx_data = acc.rd && (acc.slot == SLOT_RX_DATA);
    rd_rx_ctrl = acc.rd && (acc.slot == SLOT_RX_CTRL);
    wr_tx_data = acc.wr && (acc.slot == SLOT_TX_DATA);
    wr_ctrl    = acc.wr && ((acc.slot == SLOT_RX_CTRL) || (acc.slot == SLOT_TX_CTRL));
  end

  console_rx_port #(.BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .key_valid (key_valid),
    .key_byte  (key_byte),
    .rd_data   (rd_rx_data),
    .rd_ctrl   (rd_rx_ctrl),
    .cfg_load  (cfg_load),
    .cfg_ie    (cfg_rx_ie),
    .rdy       (rx_rdy),
    .ie        (rx_ie),
    .ovr       (rx_ovr),
    .data      (rx_data)
  );

  console_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_data  (wr_tx_data),
    .wbyte    (bus_wdata[BYTE_W-1:0]),
    .ack      (disp_ack),
    .cfg_load (cfg_load),
    .cfg_ie   (cfg_tx_ie),
    .rdy      (tx_rdy),
    .ie       (tx_ie),
    .data     (tx_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc.rd) begin
      unique case (acc.slot)
        SLOT_RX_CTRL: begin
          bus_rdata[CTRL_RDY_BIT] = rx_rdy;
          bus_rdata[CTRL_IE_BIT]  = rx_ie;
          bus_rdata[CTRL_OVR_BIT] = rx_ovr;
        end
        SLOT_RX_DATA: bus_rdata[BYTE_W-1:0] = rx_data;
        SLOT_TX_CTRL: begin
          bus_rdata[CTRL_RDY_BIT] = tx_rdy;
          bus_rdata[CTRL_IE_BIT]  = tx_ie;
        end
        SLOT_TX_DATA: bus_rdata[BYTE_W-1:0] = tx_data;
      endcase
    end
  end

  assign disp_valid = !tx_rdy;
  assign disp_byte  = tx_data;
  assign irq        = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);

  p_ctrl_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_ctrl && !cfg_load) |=> ($stable(rx_ie) && $stable(tx_ie)));

  p_enable_load_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_load |=> (rx_ie == $past(cfg_rx_ie) && tx_ie == $past(cfg_tx_ie)));

  p_data_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_rx_data || (acc.rd && acc.slot == SLOT_TX_DATA)) |->
      (bus_rdata[DATA_W-1:BYTE_W] == '0));

  p_irq_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (rx_rdy || tx_rdy));

  p_no_read_on_write_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && bus_we) |-> (bus_rdata == '0));

endmodule

// File: tb/console_mmio_test.sv
module console_mmio_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        key_valid;
  logic [7:0]  key_byte;
  logic        disp_valid;
  logic [7:0]  disp_byte;
  logic        disp_ack, cfg_load, cfg_rx_ie, cfg_tx_ie, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference model state
  bit       m_rx_rdy, m_rx_ie, m_ovr, m_tx_rdy, m_tx_ie;
  bit [7:0] m_rx_data, m_tx_data;
  int       rel = 0;

  console_mmio uut (
    .clk (clk), .rst_n (rst_n),
    .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .key_valid (key_valid), .key_byte (key_byte),
    .disp_valid (disp_valid), .disp_byte (disp_byte), .disp_ack (disp_ack),
    .cfg_load (cfg_load), .cfg_rx_ie (cfg_rx_ie), .cfg_tx_ie (cfg_tx_ie),
    .irq (irq)
  );

  always #5 clk = ~clk;

  function automatic bit in_win(input logic [31:0] a);
    return a[31:4] == 28'hFFFF000;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!(bus_sel && !bus_we && in_win(bus_addr))) return 32'h0;
    case (bus_addr[3:2])
      2'd0:    return {29'h0, m_ovr, m_rx_ie, m_rx_rdy};
      2'd1:    return {24'h0, m_rx_data};
      2'd2:    return {30'h0, m_tx_ie, m_tx_rdy};
      default: return {24'h0, m_tx_data};
    endcase
  endfunction

  task automatic model_reset();
    m_rx_rdy = 0; m_rx_ie = 0; m_ovr = 0; m_tx_rdy = 1; m_tx_ie = 0;
    m_rx_data = 0; m_tx_data = 0;
  endtask

  always @(posedge clk) begin
    bit rd_d, rd_c, wr_t, ovr_new;
    if (!rst_n) begin
      rel = 0; model_reset();
    end else if (rel < 2) begin
      rel++; model_reset();
    end else begin
      rd_d = bus_sel && !bus_we && in_win(bus_addr) && bus_addr[3:2] == 2'd1;
      rd_c = bus_sel && !bus_we && in_win(bus_addr) && bus_addr[3:2] == 2'd0;
      wr_t = bus_sel &&  bus_we && in_win(bus_addr) && bus_addr[3:2] == 2'd3;
      ovr_new = key_valid && m_rx_rdy && !rd_d;
      if (key_valid) begin m_rx_data = key_byte; m_rx_rdy = 1; end
      else if (rd_d) m_rx_rdy = 0;
      if (ovr_new) m_ovr = 1; else if (rd_c) m_ovr = 0;
      if (wr_t && m_tx_rdy) begin m_tx_data = bus_wdata[7:0]; m_tx_rdy = 0; end
      else if (disp_ack && !m_tx_rdy) m_tx_rdy = 1;
      if (cfg_load) begin m_rx_ie = cfg_rx_ie; m_tx_ie = cfg_tx_ie; end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1",  "bus_rdata",  bus_rdata, exp_rdata());
    chk("R10", "irq",        {31'h0, irq},
        {31'h0, (m_rx_rdy && m_rx_ie) || (m_tx_rdy && m_tx_ie)});
    chk("R6",  "disp_valid", {31'h0, disp_valid}, {31'h0, !m_tx_rdy});
    chk("R6",  "disp_byte",  {24'h0, disp_byte},  {24'h0, m_tx_data});
  endtask

  task automatic idle();
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    key_valid = 0; key_byte = 0; disp_ack = 0;
    cfg_load = 0; cfg_rx_ie = 0; cfg_tx_ie = 0;
  endtask

  task automatic tick();
    #2;
    if (rel >= 2 && rst_n) compare_all();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    idle();
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string req);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 chk(req, "read", bus_rdata, exp);
    tick();
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic key(input logic [7:0] b);
    key_valid = 1; key_byte = b;
    tick();
  endtask

  task automatic cfg(input bit rxe, input bit txe);
    cfg_load = 1; cfg_rx_ie = rxe; cfg_tx_ie = txe;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) tick();

    // R2: reset values
    chk("R2", "irq", {31'h0, irq}, 32'h0);
    chk("R2", "disp_valid", {31'h0, disp_valid}, 32'h0);
    rd(32'hFFFF_0000, 32'h0, "R2");
    rd(32'hFFFF_0008, 32'h1, "R2");
    rd(32'hFFFF_0004, 32'h0, "R2");

    // R9: enables into bit 1
    cfg(1, 0);
    rd(32'hFFFF_0008, 32'h1, "R9");
    rd(32'hFFFF_0000, 32'h2, "R9");

    // R3 / R10: key arrival
    key(8'h41);
    chk("R10", "irq rx", {31'h0, irq}, 32'h1);
    rd(32'hFFFF_0000, 32'h3, "R3");

    // R4: data read clears ready
    rd(32'hFFFF_0004, 32'h41, "R4");
    rd(32'hFFFF_0000, 32'h2, "R4");
    chk("R10", "irq clear", {31'h0, irq}, 32'h0);

    // R1: byte offset ignored, outside window reads zero
    key(8'h5A);
    rd(32'hFFFF_0006, 32'h5A, "R1");
    rd(32'hFFFF_0010, 32'h0, "R1");
    rd(32'h0000_0004, 32'h0, "R1");

    // R8: writes to control words and receive data ignored
    wr(32'hFFFF_0000, 32'hFFFF_FFFF);
    wr(32'hFFFF_0008, 32'hFFFF_FFFF);
    wr(32'hFFFF_0004, 32'h0000_0077);
    rd(32'hFFFF_0000, 32'h2, "R8");
    rd(32'hFFFF_0008, 32'h1, "R8");
    chk("R8", "disp_valid", {31'h0, disp_valid}, 32'h0);

    // R5: overrun and its clear
    key(8'h11);
    key(8'h22);
    rd(32'hFFFF_0000, 32'h7, "R5");
    rd(32'hFFFF_0000, 32'h3, "R5");
    rd(32'hFFFF_0004, 32'h22, "R5");

    // R4: read and key arrival in one cycle
    key(8'h33);
    key_valid = 1; key_byte = 8'h44;
    rd(32'hFFFF_0004, 32'h33, "R4");
    rd(32'hFFFF_0000, 32'h3, "R4");
    rd(32'hFFFF_0004, 32'h44, "R4");

    // R5: new overrun wins over control read in the same cycle
    key(8'h01);
    key_valid = 1; key_byte = 8'h02;
    rd(32'hFFFF_0000, 32'h3, "R5");
    rd(32'hFFFF_0000, 32'h7, "R5");
    rd(32'hFFFF_0004, 32'h02, "R5");
    rd(32'hFFFF_0000, 32'h2, "R5");

    // R6 / R7 / R11: transmit handshake
    cfg(0, 1);
    chk("R10", "irq tx", {31'h0, irq}, 32'h1);
    wr(32'hFFFF_000C, 32'h1234_56C3);
    chk("R6", "disp_valid", {31'h0, disp_valid}, 32'h1);
    chk("R6", "disp_byte", {24'h0, disp_byte}, 32'hC3);
    rd(32'hFFFF_0008, 32'h2, "R6");
    wr(32'hFFFF_000C, 32'h0000_0099);
    chk("R7", "disp_byte", {24'h0, disp_byte}, 32'hC3);
    repeat (3) tick();
    chk("R6", "disp_valid held", {31'h0, disp_valid}, 32'h1);
    disp_ack = 1; tick();
    chk("R6", "disp_valid after ack", {31'h0, disp_valid}, 32'h0);
    rd(32'hFFFF_0008, 32'h3, "R6");
    disp_ack = 1; tick();
    rd(32'hFFFF_0008, 32'h3, "R11");
    rd(32'hFFFF_000C, 32'hC3, "R6");
    disp_ack = 1;
    wr(32'hFFFF_000C, 32'h0000_005E);
    chk("R11", "disp_valid", {31'h0, disp_valid}, 32'h1);
    chk("R6", "disp_byte", {24'h0, disp_byte}, 32'h5E);
    disp_ack = 1; tick();

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bus_sel   = ($urandom % 4) != 0;
      bus_we    = $urandom % 2;
      bus_addr  = (($urandom % 16) == 0) ? $urandom : (32'hFFFF_0000 | ($urandom % 16));
      bus_wdata = $urandom;
      key_valid = ($urandom % 3) == 0;
      key_byte  = $urandom;
      disp_ack  = ($urandom % 3) == 0;
      cfg_load  = ($urandom % 16) == 0;
      cfg_rx_ie = $urandom % 2;
      cfg_tx_ie = $urandom % 2;
      tick();
    end

    finish_run();
  end

endmodule